// File: doc/BRIEF.md
# Adaptive Prefetch Enable Controller

This block decides at run time whether a hardware prefetcher should be on. Each decision starts with a pair of trial windows of equal length, counted in retired instructions. In the first window the prefetcher is on, and in the second it is off. A free-running cycle counter is stamped when the pair starts, at the switch between the two windows, and when the second window ends. The two elapsed times are then compared. If the window with the prefetcher off took strictly longer, the prefetcher is turned on for a long run phase. Otherwise it stays off.

The run phase also lasts a programmed number of retired instructions. When it ends, a new trial pair starts at once. The retirement input can report up to four retirements in one cycle. Software sets the trial length and the run length. Software then raises the enable and pulses start. Dropping the enable returns the controller to its idle state at any time.

Top module: `pf_ab_ctrl`

## Requirements
- R1: After synchronous reset, `phase` is 0 (idle), `pf_en` is 1, `choice_on` is 0 and both duration outputs are 0.
- R2: In idle, a `start` pulse taken while `run_en` is high moves `phase` to 1 (trial on) on the next edge. `start` while `run_en` is low has no effect.
- R3: In phase 1, `pf_en` is 1. The window ends in the first cycle in which the retirements accumulated in it, 0 to 4 per cycle, reach or pass `trial_len`. With `trial_len` = 0 the window ends in its first cycle. The next phase is 2.
- R4: In phase 2 (trial off), `pf_en` is 0 and the same window rule applies. The next phase is 3 (decide).
- R5: `dur_on` equals the cycle count at the end of the on window minus the count at the accepting edge. `dur_off` equals the count at the end of the off window minus the count at the end of the on window. Both are unsigned differences modulo 2^CYC_W, so they stay correct when the counter wraps.
- R6: Phase 3 lasts exactly one cycle with `pf_en` 0. It is followed by phase 4 (run) with `choice_on` = 1 only if `dur_off` > `dur_on`. A tie selects off.
- R7: In phase 4, `pf_en` equals `choice_on` and stays constant. The phase ends by the window rule against `run_len` and is followed directly by phase 1.
- R8: With `run_en` low, the next phase is 0 with `pf_en` 1 from any phase. Partial counts are discarded, so a later trial starts from zero.
- R9: Retirements reported in phase 0 or phase 3 are not counted. Retirements that overshoot a limit in the cycle that ends a window are not carried into the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Controller enable; low forces idle |
| start | input | 1 | Begins a trial pair from idle |
| retire | input | 3 | Instructions retired this cycle, 0 to 4 |
| trial_len | input | 32 | Retirements per trial window |
| run_len | input | 32 | Retirements in the run phase |
| pf_en | output | 1 | Prefetcher enable |
| phase | output | 3 | 0 idle, 1 trial on, 2 trial off, 3 decide, 4 run |
| dur_on | output | CYC_W | Cycles taken by the last on window |
| dur_off | output | CYC_W | Cycles taken by the last off window |
| choice_on | output | 1 | Setting chosen by the last decision |

## Verification
The bench sweeps small trial lengths against every pair of per-cycle retirement rates for the on and off settings. These sweeps include exact ties, where a design using greater-or-equal would wrongly choose on. They also include overshooting last cycles, where a design that carried the excess would shorten the next window, and a zero length, where a design might never end the window. The bench uses an 8-bit cycle counter, so the timestamps wrap many times during the sweep. A design that compared raw timestamps, rather than taking wrapping differences, would pick the wrong setting. Retirements keep arriving during idle and decide, and a run is aborted partway through a window. A design that counted those cycles, or kept stale partial counts, would end the next run phase or window early.

// File: rtl/pf_ab_pkg.sv
package pf_ab_pkg;

    localparam int RET_W = 3;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_TON  = 3'd1,
        PH_TOFF = 3'd2,
        PH_DEC  = 3'd3,
        PH_RUN  = 3'd4
    } pf_phase_e;

    // Phases in which retirements advance a window
    function automatic logic phase_counts(input pf_phase_e ph);
        return (ph == PH_TON) || (ph == PH_TOFF) || (ph == PH_RUN);
    endfunction

endpackage

// File: rtl/pf_cycle_timer.sv
module pf_cycle_timer #(
    parameter int CYC_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CYC_W-1:0] now
);
    always_ff @(posedge clk) begin
        if (rst) now <= '0;
        else     now <= now + 1'b1;
    end
endmodule

// File: rtl/pf_window_counter.sv
module pf_window_counter #(
    parameter int CNT_W = 32,
    parameter int RET_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             cnt_en,
    input  logic [RET_W-1:0] inc,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] acc;
    logic [SUM_W-1:0] sum;

    assign sum  = {1'b0, acc} + SUM_W'(inc);
    assign done = cnt_en && (sum >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || clr || done) acc <= '0;
        else if (cnt_en)        acc <= sum[CNT_W-1:0];
    end
endmodule

// File: rtl/pf_ab_judge.sv
module pf_ab_judge #(
    parameter int CYC_W = 64
) (
    input  logic [CYC_W-1:0] t_start,
    input  logic [CYC_W-1:0] t_mid,
    input  logic [CYC_W-1:0] t_end,
    output logic [CYC_W-1:0] span_on,
    output logic [CYC_W-1:0] span_off,
    output logic             pick_on
);
    assign span_on  = t_mid - t_start;
    assign span_off = t_end - t_mid;
    assign pick_on  = span_off > span_on;
endmodule

// File: rtl/pf_ab_ctrl.sv
module pf_ab_ctrl
    import pf_ab_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int CYC_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             start,
    input  logic [2:0]       retire,
    input  logic [CNT_W-1:0] trial_len,
    input  logic [CNT_W-1:0] run_len,
    output logic             pf_en,
    output logic [2:0]       phase,
    output logic [CYC_W-1:0] dur_on,
    output logic [CYC_W-1:0] dur_off,
    output logic             choice_on
);
    pf_phase_e        state;
    logic [CYC_W-1:0] now, t_start, t_mid, t_end;
    logic [CYC_W-1:0] span_on, span_off;
    logic             pick_on, win_done, cnt_en, cnt_clr;
    logic [CNT_W-1:0] limit;

    pf_cycle_timer #(.CYC_W(CYC_W)) u_timer (
        .clk(clk), .rst(rst), .now(now)
    );

    assign cnt_en  = run_en && phase_counts(state);
    assign cnt_clr = !cnt_en;
    assign limit   = (state == PH_RUN) ? run_len : trial_len;

    pf_window_counter #(.CNT_W(CNT_W), .RET_W(RET_W)) u_win (
        .clk(clk), .rst(rst), .clr(cnt_clr), .cnt_en(cnt_en),
        .inc(retire), .limit(limit), .done(win_done)
    );

    pf_ab_judge #(.CYC_W(CYC_W)) u_judge (
        .t_start(t_start), .t_mid(t_mid), .t_end(t_end),
        .span_on(span_on), .span_off(span_off), .pick_on(pick_on)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PH_IDLE;
            t_start   <= '0;
            t_mid     <= '0;
            t_end     <= '0;
            dur_on    <= '0;
            dur_off   <= '0;
            choice_on <= 1'b0;
        end else if (!run_en) begin
            state <= PH_IDLE;
        end else begin
            unique case (state)
                PH_IDLE: if (start) begin
                    state   <= PH_TON;
                    t_start <= now;
                end
                PH_TON: if (win_done) begin
                    state <= PH_TOFF;
                    t_mid <= now;
                end
                PH_TOFF: if (win_done) begin
                    state <= PH_DEC;
                    t_end <= now;
                end
                PH_DEC: begin
                    state     <= PH_RUN;
                    dur_on    <= span_on;
                    dur_off   <= span_off;
                    choice_on <= pick_on;
                end
                PH_RUN: if (win_done) begin
                    state   <= PH_TON;
                    t_start <= now;
                end
                default: state <= PH_IDLE;
            endcase
        end
    end

    assign phase = state;
    assign pf_en = (state == PH_IDLE) || (state == PH_TON)
                || ((state == PH_RUN) && choice_on);
endmodule

// File: rtl/pf_ab_ctrl_chk.sv
module pf_ab_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       run_en,
    input logic       start,
    input logic [2:0] phase,
    input logic       pf_en
);
    assert_idle_on_R1: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd0) |-> pf_en);

    assert_start_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd0 && run_en && start) |=> (phase == 3'd1));

    assert_trial_on_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd1) |-> pf_en);

    assert_trial_off_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd2) |-> !pf_en);

    assert_decide_once_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd3 && run_en) |=> (phase == 3'd4));

    assert_run_steady_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd4 && run_en) |=> (phase != 3'd4 || $stable(pf_en)));

    assert_run_exit_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd4 && run_en) |=> (phase == 3'd4 || phase == 3'd1));

    assert_abort_R8: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (phase == 3'd0 && pf_en));
endmodule

bind pf_ab_ctrl pf_ab_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .run_en(run_en), .start(start),
    .phase(phase), .pf_en(pf_en)
);

// File: tb/pf_ab_ctrl_bench.sv
module pf_ab_ctrl_bench;
    localparam int CNT_W = 32;
    localparam int CYC_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             run_en = 1'b0;
    logic             start = 1'b0;
    logic [2:0]       retire;
    logic [CNT_W-1:0] trial_len = '0;
    logic [CNT_W-1:0] run_len = '0;
    logic             pf_en;
    logic [2:0]       phase;
    logic [CYC_W-1:0] dur_on, dur_off;
    logic             choice_on;

    int r_on = 1;
    int r_off = 1;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    // Workload model: retirement rate depends on the prefetch setting
    always_comb retire = pf_en ? 3'(r_on) : 3'(r_off);

    pf_ab_ctrl #(.CNT_W(CNT_W), .CYC_W(CYC_W)) u_pf_ab_ctrl (
        .clk(clk), .rst(rst), .run_en(run_en), .start(start),
        .retire(retire), .trial_len(trial_len), .run_len(run_len),
        .pf_en(pf_en), .phase(phase), .dur_on(dur_on), .dur_off(dur_off),
        .choice_on(choice_on)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int win_cycles(input int len, input int rate);
        if (len == 0) return 1;
        return (len + rate - 1) / rate;
    endfunction

    task automatic trial(input int k, input int n, input int ron, input int roff);
        int m, p, q, obs;
        bit exp_on;
        m = win_cycles(k, ron);
        p = win_cycles(k, roff);
        exp_on = (p > m);
        q = win_cycles(n, exp_on ? ron : roff);
        @(negedge clk);
        run_en = 1'b0; start = 1'b0;
        trial_len = CNT_W'(k); run_len = CNT_W'(n);
        r_on = ron; r_off = roff;
        @(negedge clk);
        check(phase == 3'd0 && pf_en, "R8 idle after disable", phase, 0);
        run_en = 1'b1;
        repeat (2) @(negedge clk);   // idle retirements must not count (R9)
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        obs = 0;
        while (phase == 3'd1) begin
            if (!pf_en) check(0, "R3 pf_en in trial on", pf_en, 1);
            obs++;
            @(negedge clk);
        end
        check(obs == m, "R3 on window length", obs, m);
        obs = 0;
        while (phase == 3'd2) begin
            if (pf_en) check(0, "R4 pf_en in trial off", pf_en, 0);
            obs++;
            @(negedge clk);
        end
        check(obs == p, "R4 off window length", obs, p);
        check(phase == 3'd3 && !pf_en, "R6 decide phase", phase, 3);
        @(negedge clk);
        check(phase == 3'd4, "R6 run follows decide", phase, 4);
        check(dur_on == CYC_W'(m), "R5 dur_on", dur_on, m);
        check(dur_off == CYC_W'(p), "R5 dur_off", dur_off, p);
        check(choice_on == exp_on, "R6 choice", choice_on, exp_on);
        obs = 0;
        while (phase == 3'd4) begin
            if (pf_en != exp_on) check(0, "R7 pf_en in run", pf_en, exp_on);
            obs++;
            @(negedge clk);
        end
        check(obs == q, "R7 R9 run length", obs, q);
        check(phase == 3'd1, "R7 new trial after run", phase, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ks[5] = '{0, 1, 2, 5, 8};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(phase == 3'd0, "R1 reset phase", phase, 0);
        check(pf_en == 1'b1, "R1 reset pf_en", pf_en, 1);
        check(choice_on == 1'b0 && dur_on == '0 && dur_off == '0,
              "R1 reset status", dur_on, 0);

        // start ignored while disabled (R2)
        start = 1'b1;
        repeat (3) @(negedge clk);
        check(phase == 3'd0 && pf_en, "R2 start ignored when disabled", phase, 0);
        start = 1'b0;

        // sweep: trial lengths x both retirement rates
        for (int ki = 0; ki < 5; ki++)
            for (int a = 1; a <= 4; a++)
                for (int b = 1; b <= 4; b++)
                    trial(ks[ki], 3 + a + b, a, b);

        // abort in the middle of an off window, then restart from zero (R8)
        @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        run_en = 1'b1; trial_len = 32'd12; r_on = 1; r_off = 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (15) @(negedge clk);
        check(phase == 3'd2, "R4 mid off window", phase, 2);
        run_en = 1'b0;
        @(negedge clk);
        check(phase == 3'd0 && pf_en, "R8 abort to idle", phase, 0);
        trial(6, 7, 2, 3);
        trial(7, 0, 4, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule